// File: doc/BRIEF.md
# Store Buffer with Youngest-Match Search

This block holds stores that have left the processor pipeline but have not yet been written into the first-level data cache. Each store is accepted in a single cycle as an address and data pair and placed at the tail of a small first-in first-out queue. A cache-side agent reads the oldest entry and pops it once that entry has been written into the cache. This lets store misses complete in the background.

Loads probe the buffer in parallel with the cache. The probe compares the load's word address against every occupied entry in the same cycle, without a clock edge. If several entries hold the same word, the probe returns the data of the most recently accepted one. A hit here must be preferred over the cache's answer, because the buffer holds newer data than the cache.

Top module: `store_buffer`

## Requirements
- R1: After reset the buffer is empty: `drn_valid` = 0, `ld_hit` = 0, and `st_ready` = 1.
- R2: `st_ready` is 1 whenever fewer than DEPTH entries are held. A store with `st_valid` = 1 and `st_ready` = 1 is accepted at the rising edge.
- R3: Entries leave in acceptance order. `drn_addr` and `drn_data` always show the oldest held entry, and `drn_valid` is 1 exactly when at least one entry is held.
- R4: While `drn_valid` = 1 and `drn_take` = 0, the oldest entry stays unchanged from cycle to cycle.
- R5: `ld_hit` is 1 in the same cycle when some held entry has the same word address as `ld_addr`. The word address is bits AW-1 down to OFFW, so the low OFFW byte-offset bits are ignored in the compare.
- R6: When several held entries match, `ld_data` is the data of the most recently accepted of them.
- R7: A probe sees only the entries held before the current cycle's edge. A store presented in the same cycle does not affect `ld_hit` or `ld_data`.
- R8: When the buffer is full, a store and a take in the same cycle are both performed. `st_ready` is 1 in that case, and the buffer stays full.
- R9: A store presented while `st_ready` = 0 is dropped. It never appears on the drain port.
- R10: An entry removed by `drn_take` no longer produces probe hits.
- R11: `drn_take` while the buffer is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | A store is offered |
| st_addr | input | AW | Byte address of the offered store |
| st_data | input | DW | Data of the offered store |
| st_ready | output | 1 | The offered store will be accepted this cycle |
| ld_addr | input | AW | Byte address of the load probe |
| ld_hit | output | 1 | Some held entry matches the probe word address |
| ld_data | output | DW | Data of the youngest matching entry (0 when there is no hit) |
| drn_valid | output | 1 | An entry is held |
| drn_addr | output | AW | Address of the oldest entry |
| drn_data | output | DW | Data of the oldest entry |
| drn_take | input | 1 | Remove the oldest entry at this edge |

## Verification
The embedded assertions check, on every cycle, the properties that hold locally:
- the occupancy bound,
- the stability of the oldest entry while it is not taken,
- a first store into an empty buffer appearing at the drain port on the next cycle,
- a full buffer staying full during a simultaneous store and take,
- an empty buffer ignoring takes,
- no probe hit while empty.

Only the bench's scenarios can show the rest, by comparing against a queue model:
- drain order over long runs;
- youngest-match selection among duplicate addresses, including after the pointers wrap;
- that probes ignore same-cycle stores;
- that stores dropped while full never reappear.

// File: rtl/store_buffer.sv
module store_buffer #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int OFFW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_ready,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          drn_valid,
  output logic [AW-1:0] drn_addr,
  output logic [DW-1:0] drn_data,
  input  logic          drn_take
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] cnt;

  wire do_take = drn_take && (cnt != '0);
  wire do_put  = st_valid && st_ready;

  assign st_ready  = (cnt != FULL) || drn_take;
  assign drn_valid = (cnt != '0);
  assign drn_addr  = addr_q[head];
  assign drn_data  = data_q[head];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (do_take) head <= (head == LAST) ? '0 : head + 1'b1;
      if (do_put)  tail <= (tail == LAST) ? '0 : tail + 1'b1;
      if (do_put && !do_take)      cnt <= cnt + 1'b1;
      else if (do_take && !do_put) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_put) begin
      addr_q[tail] <= st_addr;
      data_q[tail] <= st_data;
    end
  end

  // scan from oldest to youngest; the last match found wins
  always_comb begin
    ld_hit  = 1'b0;
    ld_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW-1:0] slot;
      slot = PW'((int'(head) + k) % DEPTH);
      if (k < int'(cnt) && addr_q[slot][AW-1:OFFW] == ld_addr[AW-1:OFFW]) begin
        ld_hit  = 1'b1;
        ld_data = data_q[slot];
      end
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  a_r4_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (drn_valid && !drn_take) |=> (drn_valid && $stable(drn_addr) && $stable(drn_data)));

  a_r3_first_store_exposed: assert property (@(posedge clk) disable iff (!rst_n)
    (!drn_valid && st_valid) |=> (drn_valid && drn_addr == $past(st_addr) && drn_data == $past(st_data)));

  a_r8_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL && st_valid && drn_take) |=> (cnt == FULL));

  a_r11_empty_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!drn_valid && drn_take && !st_valid) |=> !drn_valid);

  a_r5_no_hit_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !drn_valid |-> !ld_hit);

endmodule

// File: tb/store_buffer_tb_top.sv
module store_buffer_tb_top;
  localparam int AW = 32, DW = 32, DEPTH = 4, OFFW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 1'b0, drn_take = 1'b0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_ready, ld_hit, drn_valid;
  logic [DW-1:0] ld_data, drn_data;
  logic [AW-1:0] drn_addr;

  int total = 0, bad = 0;
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];

  always #10 clk = ~clk;

  store_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .OFFW(OFFW)) dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_ready(st_ready), .ld_addr(ld_addr), .ld_hit(ld_hit),
    .ld_data(ld_data), .drn_valid(drn_valid), .drn_addr(drn_addr),
    .drn_data(drn_data), .drn_take(drn_take));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int model_matches(input logic [AW-1:0] a);
    int n = 0;
    foreach (qa[i]) if (qa[i][AW-1:OFFW] == a[AW-1:OFFW]) n++;
    return n;
  endfunction

  function automatic logic [DW-1:0] model_search(input logic [AW-1:0] a);
    for (int i = qa.size() - 1; i >= 0; i--)
      if (qa[i][AW-1:OFFW] == a[AW-1:OFFW]) return qd[i];
    return '0;
  endfunction

  task automatic step(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                      input bit tk, input logic [AW-1:0] la);
    int n;
    bit exp_rdy, pop, push;
    string tag;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; drn_take = tk; ld_addr = la;
    #2;
    n = model_matches(la);
    exp_rdy = (qa.size() < DEPTH) || tk;
    chk(st_ready == exp_rdy, (qa.size() == DEPTH) ? "R8 ready" : "R2 ready", 64'(st_ready), 64'(exp_rdy));
    chk(drn_valid == (qa.size() != 0), "R3 drn_valid", 64'(drn_valid), 64'(qa.size() != 0));
    if (qa.size() != 0)
      chk(drn_addr == qa[0] && drn_data == qd[0], "R3 oldest", {drn_addr, drn_data}, {qa[0], qd[0]});
    tag = (n > 1) ? "R6 youngest" : (sv ? "R7 same-cycle" : "R5 search");
    chk(ld_hit == (n != 0), tag, 64'(ld_hit), 64'(n != 0));
    if (n != 0) chk(ld_data == model_search(la), tag, 64'(ld_data), 64'(model_search(la)));
    @(posedge clk);
    pop = tk && qa.size() != 0;
    push = sv && exp_rdy;
    if (pop) begin void'(qa.pop_front()); void'(qd.pop_front()); end
    if (push) begin qa.push_back(sa); qd.push_back(sd); end
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed = 7;
    void'($urandom(seed));
    #5;
    // R1 reset state
    chk(!drn_valid && !ld_hit && st_ready, "R1 reset", {drn_valid, ld_hit, st_ready}, 3'b001);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R11 take while empty
    step(0, 0, 0, 1, 32'h10);
    step(0, 0, 0, 0, 32'h10);
    chk(!drn_valid, "R11 empty take", 64'(drn_valid), 0);
    // R6 duplicates, R5 byte offset ignored, fill to full
    for (int i = 0; i < 4; i++) step(1, 32'h40 | 32'(i), 32'hA0 + 32'(i), 0, 32'h43);
    // R9 dropped when full
    step(1, 32'h80, 32'hDEAD, 0, 32'h41);
    step(1, 32'h84, 32'hBEEF, 0, 32'h80);
    chk(qa.size() == DEPTH && !ld_hit, "R9 dropped", 64'(ld_hit), 0);
    // R8 swap while full, then R10 drain and probe
    step(1, 32'h44, 32'h55, 1, 32'h40);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 32'h40);
    step(0, 0, 0, 0, 32'h40);
    chk(!ld_hit && !drn_valid, "R10 drained", 64'(ld_hit), 0);
    // R4 hold the oldest entry without a take
    step(1, 32'h8, 32'h1, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 32'h8);
    // random mix with a small address set for duplicates and wrap
    for (int c = 0; c < 3000; c++) begin
      logic [AW-1:0] a, l;
      a = {26'h0, 4'($urandom_range(0, 5)), 2'($urandom)};
      l = {26'h0, 4'($urandom_range(0, 5)), 2'($urandom)};
      step($urandom_range(0, 99) < 55, a, $urandom, $urandom_range(0, 99) < 45, l);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule